// File: doc/BRIEF.md
# H-Bridge Gate Command Decoder

This block turns per-FET enable requests for a full H-bridge into safe gate commands. The bridge has two legs. Each leg has a high-side enable and a low-side enable. Every enable is first cleaned by a counting deglitch filter. A small state machine per leg then decides which FET, if any, may conduct. A request for both FETs of one leg is not treated as an error and nothing is latched: it decodes to the legal Hi-Z state, so the two FETs of a leg can never conduct together.

Whenever a leg gives up a driven state, the state machine holds it Hi-Z for a fixed dead interval before either FET may turn on again. A move from an idle leg (Hi-Z for long enough) straight to high or low needs no dead interval. A global disable from the protection and sleep logic turns every gate off in the same cycle. The block also reports a 2-bit state code for each leg.

Each leg machine has four states:
- S_OFF: idle, Hi-Z.
- S_HIGH: high-side gate on.
- S_LOW: low-side gate on.
- S_DEAD: timed Hi-Z.

The transitions are:
- S_OFF to S_HIGH or S_LOW, on a one-sided request while enabled.
- S_HIGH or S_LOW to S_DEAD, when the request changes or the bridge is disabled.
- S_DEAD to S_HIGH, S_LOW or S_OFF, when the dead count expires, following the request at that moment. It goes to S_OFF if the bridge is disabled or the request is Hi-Z.

Top module: `hb_gate_ctrl`

## Requirements
- R1: A leg with high enable 1 and low enable 0 settles with its high-side gate on, its low-side gate off and state code 2'b01.
- R2: A leg with low enable 1 and high enable 0 settles with its low-side gate on, its high-side gate off and state code 2'b10.
- R3: A leg with both enables 0 settles with both gates off and state code 2'b00.
- R4: A leg with both enables 1 settles with both gates off and code 2'b00. The two gates of one leg are never on in the same cycle.
- R5: An enable input affects the leg only after it has held a new level for DGL_CYCLES consecutive rising edges. The leg state then changes on the following edge, so the latency is DGL_CYCLES+1 edges after the first sampling of the new level.
- R6: A change on an enable input lasting fewer than DGL_CYCLES edges has no effect on any gate or state code.
- R7: A direct change between high and low keeps the leg Hi-Z (code 2'b00, both gates off) for exactly DEAD_CYCLES cycles before the other gate turns on.
- R8: A leg that leaves high or low for Hi-Z stays off for at least DEAD_CYCLES cycles before either gate turns on again.
- R9: An idle leg in S_OFF goes to high or low with no dead interval, DGL_CYCLES+1 edges after the new request is first sampled.
- R10: While bridge_dis is 1, all gates are off and all codes are 2'b00 in that same cycle. A leg that was driving passes through its dead interval before it can drive again.
- R11: During and right after reset, all gates are off and all codes are 2'b00.
- R12: The two legs are decoded independently; activity on one leg does not change the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bridge_dis | input | 1 | Global disable from fault or sleep logic; forces all gates off |
| hi_en | input | NUM_LEGS | High-side enable request per leg |
| lo_en | input | NUM_LEGS | Low-side enable request per leg |
| hs_gate | output | NUM_LEGS | High-side gate command per leg |
| ls_gate | output | NUM_LEGS | Low-side gate command per leg |
| leg_state | output | 2*NUM_LEGS | Per-leg code, leg i at bits [2i+1:2i]: 00 Hi-Z, 01 high, 10 low |

## Verification
A change on an enable shows up at the gates DGL_CYCLES+1 rising edges after it is first sampled: DGL_CYCLES edges in the filter and one in the state register. Dead intervals then add exactly DEAD_CYCLES cycles, while bridge_dis clears the gates in the cycle it is applied. The bench keeps a behavioural model that advances once per rising edge. Outputs are compared on every falling edge, so each result is checked in the cycle it is due and not only after it settles. Directed phases cover glitches, both-enable requests, reversals, disable and leg independence, followed by a long run of random stimulus.

// File: rtl/hb_gate_pkg.sv
package hb_gate_pkg;

    typedef enum logic [1:0] {
        LEG_Z = 2'b00,
        LEG_H = 2'b01,
        LEG_L = 2'b10
    } leg_code_e;

    typedef enum logic [1:0] {
        S_OFF,
        S_HIGH,
        S_LOW,
        S_DEAD
    } leg_state_e;

endpackage

// File: rtl/hb_deglitch.sv
module hb_deglitch #(
    parameter int HOLD = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic filt
);
    localparam int CW = (HOLD > 1) ? $clog2(HOLD) : 1;

    logic [CW-1:0] run_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            filt    <= 1'b0;
            run_cnt <= '0;
        end else if (raw != filt) begin
            if (run_cnt == CW'(HOLD - 1)) begin
                filt    <= raw;
                run_cnt <= '0;
            end else begin
                run_cnt <= run_cnt + CW'(1);
            end
        end else begin
            run_cnt <= '0;
        end
    end
endmodule

// File: rtl/hb_leg_fsm.sv
module hb_leg_fsm
    import hb_gate_pkg::*;
#(
    parameter int DEAD_CYCLES = 6
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      dis,
    input  logic      hi_f,
    input  logic      lo_f,
    output logic      hs_on,
    output logic      ls_on,
    output leg_code_e code
);
    localparam int CW = (DEAD_CYCLES > 1) ? $clog2(DEAD_CYCLES) : 1;

    leg_state_e    state, state_n;
    logic [CW-1:0] dead_cnt;
    logic          want_h, want_l, dead_done;

    assign want_h    = hi_f & ~lo_f;
    assign want_l    = lo_f & ~hi_f;
    assign dead_done = (dead_cnt == CW'(DEAD_CYCLES - 1));

    // next-state decision
    always_comb begin
        state_n = state;
        unique case (state)
            S_OFF: begin
                if (!dis && want_h)      state_n = S_HIGH;
                else if (!dis && want_l) state_n = S_LOW;
            end
            S_HIGH: if (dis || !want_h) state_n = S_DEAD;
            S_LOW:  if (dis || !want_l) state_n = S_DEAD;
            S_DEAD: begin
                if (dead_done) begin
                    if (dis)         state_n = S_OFF;
                    else if (want_h) state_n = S_HIGH;
                    else if (want_l) state_n = S_LOW;
                    else             state_n = S_OFF;
                end
            end
        endcase
    end

    // state register and dead-interval counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= S_OFF;
            dead_cnt <= '0;
        end else begin
            state <= state_n;
            if (state != S_DEAD)
                dead_cnt <= '0;
            else
                dead_cnt <= dead_cnt + CW'(1);
        end
    end

    // outputs, gated by the global disable
    always_comb begin
        hs_on = 1'b0;
        ls_on = 1'b0;
        code  = LEG_Z;
        unique case (state)
            S_HIGH: if (!dis) begin hs_on = 1'b1; code = LEG_H; end
            S_LOW:  if (!dis) begin ls_on = 1'b1; code = LEG_L; end
            S_OFF, S_DEAD: ;
        endcase
    end
endmodule

// File: rtl/hb_gate_ctrl.sv
module hb_gate_ctrl
    import hb_gate_pkg::*;
#(
    parameter int NUM_LEGS    = 2,
    parameter int DGL_CYCLES  = 4,
    parameter int DEAD_CYCLES = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bridge_dis,
    input  logic [NUM_LEGS-1:0]   hi_en,
    input  logic [NUM_LEGS-1:0]   lo_en,
    output logic [NUM_LEGS-1:0]   hs_gate,
    output logic [NUM_LEGS-1:0]   ls_gate,
    output logic [2*NUM_LEGS-1:0] leg_state
);
    for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
        logic      hi_f, lo_f;
        leg_code_e code;

        hb_deglitch #(.HOLD(DGL_CYCLES)) u_dg_hi (
            .clk(clk), .rst_n(rst_n), .raw(hi_en[g]), .filt(hi_f)
        );
        hb_deglitch #(.HOLD(DGL_CYCLES)) u_dg_lo (
            .clk(clk), .rst_n(rst_n), .raw(lo_en[g]), .filt(lo_f)
        );
        hb_leg_fsm #(.DEAD_CYCLES(DEAD_CYCLES)) u_fsm (
            .clk(clk), .rst_n(rst_n), .dis(bridge_dis),
            .hi_f(hi_f), .lo_f(lo_f),
            .hs_on(hs_gate[g]), .ls_on(ls_gate[g]), .code(code)
        );
        assign leg_state[2*g +: 2] = code;
    end
endmodule

// File: rtl/hb_gate_ctrl_chk.sv
module hb_gate_ctrl_chk #(
    parameter int NUM_LEGS    = 2,
    parameter int DEAD_CYCLES = 6
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  bridge_dis,
    input logic [NUM_LEGS-1:0]   hs_gate,
    input logic [NUM_LEGS-1:0]   ls_gate,
    input logic [2*NUM_LEGS-1:0] leg_state
);
    localparam int IW = $clog2(DEAD_CYCLES + 1);

    for (genvar i = 0; i < NUM_LEGS; i++) begin : g_chk
        logic [IW-1:0] hs_idle, ls_idle;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                hs_idle <= IW'(DEAD_CYCLES);
                ls_idle <= IW'(DEAD_CYCLES);
            end else begin
                if (hs_gate[i])                        hs_idle <= '0;
                else if (hs_idle < IW'(DEAD_CYCLES))   hs_idle <= hs_idle + IW'(1);
                if (ls_gate[i])                        ls_idle <= '0;
                else if (ls_idle < IW'(DEAD_CYCLES))   ls_idle <= ls_idle + IW'(1);
            end
        end

        p_no_shoot_r4: assert property (@(posedge clk) disable iff (!rst_n)
            !(hs_gate[i] && ls_gate[i]));

        p_dead_before_ls_r7: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(ls_gate[i]) |-> hs_idle >= IW'(DEAD_CYCLES));

        p_dead_before_hs_r7: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(hs_gate[i]) |-> ls_idle >= IW'(DEAD_CYCLES));

        p_disable_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
            bridge_dis |-> (!hs_gate[i] && !ls_gate[i] && leg_state[2*i +: 2] == 2'b00));

        p_code_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
            hs_gate[i] |-> leg_state[2*i +: 2] == 2'b01);

        p_code_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
            ls_gate[i] |-> leg_state[2*i +: 2] == 2'b10);
    end
endmodule

bind hb_gate_ctrl hb_gate_ctrl_chk #(
    .NUM_LEGS(NUM_LEGS),
    .DEAD_CYCLES(DEAD_CYCLES)
) u_chk (
    .clk(clk),
    .rst_n(rst_n),
    .bridge_dis(bridge_dis),
    .hs_gate(hs_gate),
    .ls_gate(ls_gate),
    .leg_state(leg_state)
);

// File: tb/hb_gate_ctrl_bench.sv
`timescale 1ns/1ps
module hb_gate_ctrl_bench;
    localparam int NL   = 2;
    localparam int DGL  = 4;
    localparam int DEAD = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bridge_dis = 1'b0;
    logic [NL-1:0] hi_en = '0;
    logic [NL-1:0] lo_en = '0;
    logic [NL-1:0] hs_gate, ls_gate;
    logic [2*NL-1:0] leg_state;

    int checks = 0;
    int failures = 0;
    string phase = "R11 reset";

    always #4 clk = ~clk;

    hb_gate_ctrl #(.NUM_LEGS(NL), .DGL_CYCLES(DGL), .DEAD_CYCLES(DEAD)) u_hb_gate_ctrl (
        .clk(clk), .rst_n(rst_n), .bridge_dis(bridge_dis),
        .hi_en(hi_en), .lo_en(lo_en),
        .hs_gate(hs_gate), .ls_gate(ls_gate), .leg_state(leg_state)
    );

    // behavioural reference: 0 idle, 1 high, 2 low, 3 timed Hi-Z
    int mode [NL];
    int dcnt [NL];
    int hrun [NL];
    int lrun [NL];
    bit hlev [NL];
    bit llev [NL];

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NL; i++) begin
                mode[i] = 0; dcnt[i] = 0; hrun[i] = 0; lrun[i] = 0;
                hlev[i] = 0; llev[i] = 0;
            end
        end else begin
            for (int i = 0; i < NL; i++) begin
                bit rh, rl;
                rh = hlev[i] && !llev[i];
                rl = llev[i] && !hlev[i];
                case (mode[i])
                    0: if (!bridge_dis) begin
                           if (rh) mode[i] = 1;
                           else if (rl) mode[i] = 2;
                       end
                    1: if (bridge_dis || !rh) begin mode[i] = 3; dcnt[i] = 0; end
                    2: if (bridge_dis || !rl) begin mode[i] = 3; dcnt[i] = 0; end
                    default: begin
                        if (dcnt[i] == DEAD - 1) begin
                            if (bridge_dis) mode[i] = 0;
                            else if (rh)    mode[i] = 1;
                            else if (rl)    mode[i] = 2;
                            else            mode[i] = 0;
                        end else begin
                            dcnt[i]++;
                        end
                    end
                endcase
                if (hi_en[i] != hlev[i]) begin
                    hrun[i]++;
                    if (hrun[i] == DGL) begin hlev[i] = hi_en[i]; hrun[i] = 0; end
                end else hrun[i] = 0;
                if (lo_en[i] != llev[i]) begin
                    lrun[i]++;
                    if (lrun[i] == DGL) begin llev[i] = lo_en[i]; lrun[i] = 0; end
                end else lrun[i] = 0;
            end
        end
    end

    task automatic check_bit(string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s at %0t: actual=%0b expected=%0b", phase, what, $time, act, exp);
        end
    endtask

    task automatic compare();
        for (int i = 0; i < NL; i++) begin
            logic eh, el;
            logic [1:0] ec, ac;
            eh = (mode[i] == 1) && !bridge_dis && rst_n;
            el = (mode[i] == 2) && !bridge_dis && rst_n;
            ec = eh ? 2'b01 : (el ? 2'b10 : 2'b00);
            ac = leg_state[2*i +: 2];
            check_bit($sformatf("hs_gate[%0d]", i), hs_gate[i], eh);
            check_bit($sformatf("ls_gate[%0d]", i), ls_gate[i], el);
            checks++;
            if (ac !== ec) begin
                failures++;
                $display("FAIL %s leg_state[%0d] at %0t: actual=%0b expected=%0b", phase, i, $time, ac, ec);
            end
        end
    endtask

    task automatic run(int n);
        repeat (n) begin
            @(negedge clk);
            compare();
        end
    endtask

    task automatic finish_run();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        phase = "R11 reset";
        run(3);
        rst_n = 1'b1;
        run(3);

        phase = "R1 R9 leg0 high from idle";
        hi_en[0] = 1'b1;
        run(DGL + 4);

        phase = "R6 short glitch on leg1 low";
        lo_en[1] = 1'b1;
        run(DGL - 1);
        lo_en[1] = 1'b0;
        run(DGL + 4);

        phase = "R7 R2 leg0 high to low";
        hi_en[0] = 1'b0; lo_en[0] = 1'b1;
        run(DGL + DEAD + 5);

        phase = "R4 leg0 both enables";
        hi_en[0] = 1'b1;
        run(DGL + DEAD + 5);

        phase = "R3 leg0 both clear";
        hi_en[0] = 1'b0; lo_en[0] = 1'b0;
        run(DGL + 4);

        phase = "R9 R5 leg1 idle to high";
        hi_en[1] = 1'b1;
        run(DGL + 4);

        phase = "R2 R12 leg1 reverses while leg0 rises";
        hi_en[1] = 1'b0; lo_en[1] = 1'b1; hi_en[0] = 1'b1;
        run(DGL + DEAD + 5);

        phase = "R10 disable";
        bridge_dis = 1'b1;
        run(DEAD + 3);
        bridge_dis = 1'b0;
        run(DEAD + 5);

        phase = "R8 high to Hi-Z then low";
        hi_en[0] = 1'b0;
        run(DGL + 2);
        lo_en[0] = 1'b1;
        run(DGL + DEAD + 5);

        phase = "R5 R7 R10 R12 random mix";
        for (int k = 0; k < 400; k++) begin
            int r;
            r = $urandom_range(0, 15);
            if (r < 3) hi_en[$urandom_range(0, 1)] ^= 1'b1;
            else if (r < 6) lo_en[$urandom_range(0, 1)] ^= 1'b1;
            else if (r == 6) bridge_dis = ~bridge_dis;
            run($urandom_range(1, DGL + DEAD));
        end
        bridge_dis = 1'b0;
        run(20);

        finish_run();
    end
endmodule